// File: doc/BRIEF.md
# Flash Memory Controller with Erase

This block fronts an on-chip NOR flash array and a small store of user-configuration words. Software reaches everything through one 32-bit, word-only, little-endian access port. A region select picks one of three spaces: the control registers, the user-configuration words or the flash array. A two-bit configuration register gates flash programming and erasing. Programming follows NOR rules: a write can only clear bits, and only an erase sets them again.

Three control registers start erases. Either of two page-erase registers erases one page. A keyed full-chip erase clears the whole array and the configuration words. A keyed configuration-area erase clears only the user-configuration words, and it needs no enable. Page and full-chip erases run as a sweep that writes one word per cycle. A ready register shows when a sweep is running, and flash writes or erase requests that arrive during a sweep are dropped. The array is a synchronous RAM model inside the block. Its default size is kept small (16 pages of 16 words), and the page and page-count parameters must be powers of two.

Top module: `nvm_flash_ctrl`

## Requirements
- R1: A read strobe returns the addressed word on `bus_rdata`, with `bus_rvalid` high, in the cycle after the strobe. Region select codes are 0 for control, 1 for user configuration, 2 for flash and 3 for none; region 3 reads 0.
- R2: The configuration register sits at control offset 0x004 and keeps only bits [1:0]. Bit 0 enables programming and bit 1 enables erasing. It resets to 0, and it reads back with bits [31:2] zero.
- R3: With bit 0 set, a flash write stores the old word AND the new data. With bit 0 clear, the write leaves the word unchanged.
- R4: A write to control offset 0x008 or 0x00C clears the in-page byte bits of the written value to form a page base. If erasing is enabled and the base is no higher than flash bytes minus page bytes, every word of that page becomes 0xFFFFFFFF and no other word changes.
- R5: A page-erase write is ignored when erasing is disabled or when the page base is out of range. No sweep starts and the flash is unchanged.
- R6: Writing the key 0x00000001 to control offset 0x010 with erasing enabled sets every flash word and every user-configuration word to all ones. Any other value, or erasing disabled, has no effect.
- R7: Writing the key 0x00000001 to control offset 0x014 sets all user-configuration words to all ones, whatever the configuration register holds. Other values are ignored.
- R8: User-configuration words reset to 0xFFFFFFFF and can be read and written directly, with no enable.
- R9: Control offset 0x000 reads 1 when idle and 0 while a sweep runs. A page sweep lasts one cycle per page word, and a full-chip sweep lasts one cycle per flash word.
- R10: During a sweep, flash writes and new page or full-chip erase requests are ignored.
- R11: Reads from undefined control offsets return 0, and writes to them are ignored. Flash or user-configuration accesses beyond the implemented words read 0, and writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Region select: 0 control, 1 user configuration, 2 flash, 3 none |
| bus_addr | input | 32 | Byte address within the selected region |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The sweep's own word writes can overlap in time with software traffic: a flash program, a second page erase or a keyed full-chip erase can land while a sweep is still running. The bench starts a page sweep and, within the sweep window, issues a clearing write to another page, a request for a different page and a keyed full-chip erase. It then waits for ready and reads back the whole array against its model, where only the first page is erased and the earlier contents elsewhere remain. The exact sweep length seen through the ready register is compared against the page and full-chip word counts.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    RGN_CTRL  = 2'd0,
    RGN_UCFG  = 2'd1,
    RGN_FLASH = 2'd2,
    RGN_NONE  = 2'd3
  } rgn_e;

  typedef enum logic {SW_IDLE = 1'b0, SW_RUN = 1'b1} sweep_e;

  localparam logic [31:0] OFS_READY   = 32'h000;
  localparam logic [31:0] OFS_CFG     = 32'h004;
  localparam logic [31:0] OFS_PGERA_A = 32'h008;
  localparam logic [31:0] OFS_PGERA_B = 32'h00C;
  localparam logic [31:0] OFS_ALLERA  = 32'h010;
  localparam logic [31:0] OFS_UCERA   = 32'h014;
  localparam logic [31:0] ERASE_KEY   = 32'h0000_0001;
endpackage

// File: rtl/nvm_erase_seq.sv
module nvm_erase_seq #(
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 16,
  localparam int FLASH_WORDS = PAGE_WORDS * NUM_PAGES,
  localparam int IDX_W = $clog2(FLASH_WORDS),
  localparam int PW_AW = $clog2(PAGE_WORDS),
  localparam int PG_AW = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_req,
  input  logic [PG_AW-1:0] pg_idx,
  input  logic             all_req,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  import nvm_pkg::*;

  sweep_e           state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d, last_q, last_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    last_d  = last_q;
    case (state_q)
      SW_IDLE: begin
        if (all_req) begin
          state_d = SW_RUN;
          ptr_d   = '0;
          last_d  = IDX_W'(FLASH_WORDS - 1);
        end else if (pg_req) begin
          state_d = SW_RUN;
          ptr_d   = {pg_idx, {PW_AW{1'b0}}};
          last_d  = {pg_idx, {PW_AW{1'b1}}};
        end
      end
      default: begin
        if (ptr_q == last_q) state_d = SW_IDLE;
        else                 ptr_d = ptr_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      ptr_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      last_q  <= last_d;
    end
  end

  assign busy   = (state_q == SW_RUN);
  assign wr_en  = busy;
  assign wr_idx = ptr_q;

  // R10: requests arriving mid-sweep do not disturb the walk
  a_r10_sweep_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (ptr_q != last_q) |=> busy && (ptr_q == IDX_W'($past(ptr_q) + 1'b1))
                                  && (last_q == $past(last_q)));
  // R9: the sweep ends right after its last word
  a_r9_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (ptr_q == last_q) |=> !busy);
endmodule

// File: rtl/nvm_ucfg_store.sv
module nvm_ucfg_store #(
  parameter int WORDS = 8,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  input  logic          wipe,
  output logic [31:0]   rdata
);
  logic [31:0] words_q [WORDS];
  logic [31:0] words_d [WORDS];

  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      if (wipe)                        words_d[i] = '1;
      else if (we && (idx == AW'(i)))  words_d[i] = wdata;
      else                             words_d[i] = words_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words_q[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) words_q[i] <= words_d[i];
    end
  end

  assign rdata = words_q[idx];

  for (genvar g = 0; g < WORDS; g++) begin : g_chk
    // R7: a wipe leaves every word all ones
    a_r7_wipe_ones: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> words_q[g] == 32'hFFFF_FFFF);
    // R8: a direct write lands unmodified
    a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      we && !wipe && (idx == AW'(g)) |=> words_q[g] == $past(wdata));
  end
endmodule

// File: rtl/nvm_flash_array.sv
module nvm_flash_array #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_idx,
  input  logic [31:0]   prog_data,
  input  logic          sweep_we,
  input  logic [AW-1:0] sweep_idx,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (sweep_we)     mem[sweep_idx] <= '1;
    else if (prog_we) mem[prog_idx]  <= mem[prog_idx] & prog_data;
  end

  assign rd_data = mem[rd_idx];

  // R3: programming can only clear bits
  a_r3_and_only: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we && !sweep_we |=> mem[$past(prog_idx)] == ($past(mem[prog_idx]) & $past(prog_data)));
  // R4: each swept word becomes all ones
  a_r4_sweep_ones: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_we |=> mem[$past(sweep_idx)] == 32'hFFFF_FFFF);
  // R10: the program port is idle while the sweep writes
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_we && prog_we));
endmodule

// File: rtl/nvm_flash_ctrl.sv
module nvm_flash_ctrl #(
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 16,
  parameter int UCFG_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_sel,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid
);
  import nvm_pkg::*;

  localparam int FLASH_WORDS = PAGE_WORDS * NUM_PAGES;
  localparam int PAGE_BYTES  = PAGE_WORDS * 4;
  localparam int FLASH_BYTES = FLASH_WORDS * 4;
  localparam int IDX_W = $clog2(FLASH_WORDS);
  localparam int PW_AW = $clog2(PAGE_WORDS);
  localparam int PG_AW = $clog2(NUM_PAGES);
  localparam int UC_AW = $clog2(UCFG_WORDS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic        ctrl_wr, ctrl_rd_sel, busy, sweep_we;
  logic [IDX_W-1:0] sweep_idx;
  logic [1:0]  cfg_q, cfg_d;
  logic [31:0] pg_base, fl_rdata, uc_rdata, rd_mux, rdata_q, rdata_d;
  logic        pg_ok, pg_req, all_req, uc_wipe, fl_hit, uc_hit, prog_we, uc_we;
  logic        rvalid_q;

  assign ctrl_wr     = bus_we && (bus_sel == RGN_CTRL);
  assign ctrl_rd_sel = (bus_sel == RGN_CTRL);
  assign pg_base     = bus_wdata & ~32'(PAGE_BYTES - 1);
  assign pg_ok       = (pg_base <= 32'(FLASH_BYTES - PAGE_BYTES));
  assign pg_req      = ctrl_wr && ((bus_addr == OFS_PGERA_A) || (bus_addr == OFS_PGERA_B))
                       && cfg_q[1] && pg_ok && !busy;
  assign all_req     = ctrl_wr && (bus_addr == OFS_ALLERA) && (bus_wdata == ERASE_KEY)
                       && cfg_q[1] && !busy;
  assign uc_wipe     = (ctrl_wr && (bus_addr == OFS_UCERA) && (bus_wdata == ERASE_KEY)) || all_req;
  assign fl_hit      = (bus_addr < 32'(FLASH_BYTES));
  assign uc_hit      = (bus_addr < 32'(UCFG_WORDS * 4));
  assign prog_we     = bus_we && (bus_sel == RGN_FLASH) && fl_hit && cfg_q[0] && !busy;
  assign uc_we       = bus_we && (bus_sel == RGN_UCFG) && uc_hit;

  assign cfg_d = (ctrl_wr && (bus_addr == OFS_CFG)) ? bus_wdata[1:0] : cfg_q;

  nvm_erase_seq #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_seq (
    .clk(clk), .rst_n(rst_ns), .pg_req(pg_req),
    .pg_idx(pg_base[PW_AW+2 +: PG_AW]), .all_req(all_req),
    .busy(busy), .wr_en(sweep_we), .wr_idx(sweep_idx)
  );

  nvm_flash_array #(.WORDS(FLASH_WORDS)) u_arr (
    .clk(clk), .rst_n(rst_ns), .prog_we(prog_we), .prog_idx(bus_addr[2 +: IDX_W]),
    .prog_data(bus_wdata), .sweep_we(sweep_we), .sweep_idx(sweep_idx),
    .rd_idx(bus_addr[2 +: IDX_W]), .rd_data(fl_rdata)
  );

  nvm_ucfg_store #(.WORDS(UCFG_WORDS)) u_ucfg (
    .clk(clk), .rst_n(rst_ns), .we(uc_we), .idx(bus_addr[2 +: UC_AW]),
    .wdata(bus_wdata), .wipe(uc_wipe), .rdata(uc_rdata)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_sel)
      RGN_CTRL: begin
        if (bus_addr == OFS_READY)    rd_mux = {31'b0, !busy};
        else if (bus_addr == OFS_CFG) rd_mux = {30'b0, cfg_q};
      end
      RGN_UCFG:  if (uc_hit) rd_mux = uc_rdata;
      RGN_FLASH: if (fl_hit) rd_mux = fl_rdata;
      default:   rd_mux = '0;
    endcase
  end

  assign rdata_d = bus_re ? rd_mux : rdata_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      rdata_q  <= rdata_d;
      rvalid_q <= bus_re;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R1: every read strobe is answered in the next cycle
  a_r1_rvalid: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_re |=> bus_rvalid);
  // R2: a configuration write keeps only its two low bits
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_ns)
    ctrl_wr && (bus_addr == OFS_CFG) |=> bus_rdata[31:2] == $past(bus_rdata[31:2]) && cfg_q == $past(bus_wdata[1:0]));
  // R9: ready reads 0 while the sweep runs
  a_r9_ready_busy: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_re && ctrl_rd_sel && (bus_addr == OFS_READY) && sweep_we |=> bus_rdata == 32'h0);
  // R5: a page erase without the erase enable starts nothing
  a_r5_no_enable: assert property (@(posedge clk) disable iff (!rst_ns)
    ctrl_wr && (bus_addr == OFS_PGERA_A) && !cfg_q[1] && !sweep_we |=> !sweep_we);
endmodule

// File: tb/sim_nvm_flash_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_flash_ctrl;
  localparam int PW  = 16;
  localparam int NP  = 16;
  localparam int UCW = 8;
  localparam int FW  = PW * NP;
  localparam int PB  = PW * 4;
  localparam int FB  = FW * 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_sel;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_we, bus_re, bus_rvalid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_fl [FW];
  logic [31:0] exp_uc [UCW];
  logic [1:0]  exp_cfg;

  always #2 clk = ~clk;

  nvm_flash_ctrl #(.PAGE_WORDS(PW), .NUM_PAGES(NP), .UCFG_WORDS(UCW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  function automatic logic [31:0] f_prog(logic [31:0] old_w, logic [31:0] new_w);
    return old_w & new_w;
  endfunction
  function automatic logic [31:0] f_base(logic [31:0] v);
    return v & ~32'(PB - 1);
  endfunction
  function automatic bit f_base_ok(logic [31:0] v);
    return f_base(v) <= 32'(FB - PB);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [31:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_sel = sel; bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_sel = 2'd3;
  endtask

  task automatic bus_rd(logic [1:0] sel, logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_sel = sel; bus_addr = addr; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    data = bus_rdata;
  endtask

  // polls ready back to back; returns the number of busy samples
  task automatic wait_idle(output int cyc);
    bus_sel = 2'd0; bus_addr = 32'h0; bus_re = 1'b1; cyc = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (bus_rdata[0]) break;
      cyc++;
    end
    bus_re = 1'b0;
  endtask

  task automatic m_cfg(logic [31:0] v);
    bus_wr(2'd0, 32'h004, v);
    exp_cfg = v[1:0];
  endtask

  task automatic m_prog(logic [31:0] addr, logic [31:0] data);
    bus_wr(2'd2, addr, data);
    if (addr < FB && exp_cfg[0]) exp_fl[addr[31:2]] = f_prog(exp_fl[addr[31:2]], data);
  endtask

  task automatic m_page(logic [31:0] ofs, logic [31:0] v, string req);
    int c;
    bit go;
    bus_wr(2'd0, ofs, v);
    go = exp_cfg[1] && f_base_ok(v);
    if (go) for (int i = 0; i < PW; i++) exp_fl[f_base(v)/4 + i] = 32'hFFFF_FFFF;
    wait_idle(c);
    check(req, c, go ? PW : 0);
  endtask

  task automatic m_all(logic [31:0] v);
    int c;
    bit go;
    bus_wr(2'd0, 32'h010, v);
    go = exp_cfg[1] && (v == 32'h1);
    if (go) begin
      for (int i = 0; i < FW; i++) exp_fl[i] = 32'hFFFF_FFFF;
      for (int i = 0; i < UCW; i++) exp_uc[i] = 32'hFFFF_FFFF;
    end
    wait_idle(c);
    check("R6/R9 full sweep length", c, go ? FW : 0);
  endtask

  task automatic m_ucera(logic [31:0] v);
    bus_wr(2'd0, 32'h014, v);
    if (v == 32'h1) for (int i = 0; i < UCW; i++) exp_uc[i] = 32'hFFFF_FFFF;
  endtask

  task automatic verify_all(string req);
    logic [31:0] d;
    for (int i = 0; i < FW; i++) begin
      bus_rd(2'd2, 32'(i * 4), d);
      check(req, d, exp_fl[i]);
    end
    for (int i = 0; i < UCW; i++) begin
      bus_rd(2'd1, 32'(i * 4), d);
      check(req, d, exp_uc[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] a;
    int c;
    int seed_set;
    seed_set = $urandom(32'h5EED);
    rst_n = 1'b0; bus_sel = 2'd3; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    exp_cfg = 2'b00;
    for (int i = 0; i < UCW; i++) exp_uc[i] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    bus_rd(2'd0, 32'h004, d); check("R2 cfg reset", d, 32'h0);
    check("R1 rvalid after read", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk);
    check("R1 rvalid drops", {31'b0, bus_rvalid}, 32'h0);
    bus_rd(2'd0, 32'h000, d); check("R9 ready idle", d, 32'h1);
    bus_rd(2'd3, 32'h000, d); check("R1 region none reads 0", d, 32'h0);
    for (int i = 0; i < UCW; i++) begin
      bus_rd(2'd1, 32'(i * 4), d); check("R8 ucfg reset ones", d, 32'hFFFF_FFFF);
    end

    // config masking
    m_cfg(32'hFFFF_FFFF);
    bus_rd(2'd0, 32'h004, d); check("R2 cfg masked", d, 32'h3);

    // user words written directly, then a full erase
    m_cfg(32'h0);
    bus_wr(2'd1, 32'hC, 32'h1234_5678); exp_uc[3] = 32'h1234_5678;
    bus_rd(2'd1, 32'hC, d); check("R8 ucfg direct write", d, 32'h1234_5678);
    m_all(32'h1);                       // erase disabled
    m_cfg(32'h2);
    m_all(32'h2);                       // wrong key
    bus_rd(2'd1, 32'hC, d); check("R6 wrong key keeps ucfg", d, 32'h1234_5678);
    m_all(32'h1);
    verify_all("R6 full erase");

    // programming
    m_prog(32'h40, 32'h0);              // write disabled
    bus_rd(2'd2, 32'h40, d); check("R3 write dropped", d, 32'hFFFF_FFFF);
    m_cfg(32'h1);
    m_prog(32'h40, 32'hF0F0_F0F0);
    m_prog(32'h40, 32'h3C3C_FFFF);
    bus_rd(2'd2, 32'h40, d); check("R3 AND semantics", d, 32'h3030_F0F0);
    for (int i = 0; i < FW; i++) m_prog(32'(i * 4), 32'(i) ^ 32'hA5A5_0000);

    // page erase
    m_page(32'h008, 32'(2 * PB + 8), "R5 no erase enable");
    m_cfg(32'h3);
    m_page(32'h008, 32'(2 * PB + 8), "R4 page erase A");
    m_page(32'h00C, 32'(5 * PB + 60), "R4 page erase B");
    m_page(32'h008, 32'(FB), "R5 out of range");
    m_page(32'h00C, 32'hFFFF_FFF0, "R5 far out of range");
    m_page(32'h008, 32'(FB - PB + 5), "R4 last page");
    verify_all("R4 page contents");

    // user area erase ignores the erase enable
    m_cfg(32'h0);
    bus_wr(2'd1, 32'h0, 32'h0000_0042); exp_uc[0] = 32'h42;
    m_ucera(32'h2);
    bus_rd(2'd1, 32'h0, d); check("R7 wrong value ignored", d, 32'h42);
    m_ucera(32'h1);
    bus_rd(2'd1, 32'h0, d); check("R7 erase without enable", d, 32'hFFFF_FFFF);

    // undefined and out-of-range accesses
    bus_rd(2'd0, 32'h018, d); check("R11 undefined reads 0", d, 32'h0);
    bus_wr(2'd0, 32'h018, 32'h3);
    bus_rd(2'd0, 32'h004, d); check("R11 undefined write ignored", d, 32'h0);
    bus_rd(2'd2, 32'(FB), d); check("R11 flash beyond reads 0", d, 32'h0);
    bus_rd(2'd1, 32'(UCW * 4), d); check("R11 ucfg beyond reads 0", d, 32'h0);
    bus_wr(2'd1, 32'(UCW * 4), 32'h0);
    m_cfg(32'h1);
    m_prog(32'(FB), 32'h0);
    verify_all("R11 out-of-range writes ignored");

    // random mix
    for (int n = 0; n < 300; n++) begin
      case ($urandom_range(0, 5))
        0: m_cfg($urandom());
        1: m_prog({22'b0, 8'($urandom_range(0, FW - 1)), 2'b0}, $urandom() | $urandom());
        2: begin
          a = {29'b0, 3'($urandom_range(0, UCW - 1)), 2'b0};
          d = $urandom();
          bus_wr(2'd1, a, d); exp_uc[a[4:2]] = d;
        end
        3: m_page(($urandom_range(0, 1) != 0) ? 32'h008 : 32'h00C,
                  32'($urandom_range(0, FB + 2 * PB)), "R4/R5 random page");
        4: begin
          a = {22'b0, 8'($urandom_range(0, FW - 1)), 2'b0};
          bus_rd(2'd2, a, d); check("R3 random read", d, exp_fl[a[31:2]]);
        end
        default: begin
          a = {29'b0, 3'($urandom_range(0, UCW - 1)), 2'b0};
          bus_rd(2'd1, a, d); check("R8 random read", d, exp_uc[a[4:2]]);
        end
      endcase
    end
    verify_all("R3/R4 random end state");

    // requests landing during a sweep
    m_cfg(32'h3);
    for (int i = 0; i < FW; i++) m_prog(32'(i * 4), 32'h7777_7777);
    bus_wr(2'd0, 32'h008, 32'(1 * PB));
    for (int i = 0; i < PW; i++) exp_fl[PW + i] = 32'hFFFF_FFFF;
    bus_wr(2'd2, 32'(5 * PB), 32'h0);
    bus_wr(2'd0, 32'h00C, 32'(3 * PB));
    bus_wr(2'd0, 32'h010, 32'h1);
    wait_idle(c);
    verify_all("R10 requests during sweep ignored");
    bus_rd(2'd0, 32'h000, d); check("R9 ready after sweep", d, 32'h1);

    summary();
  end
endmodule